// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block lets software run single conversions on an external successive-approximation converter with several multiplexed inputs. Software writes an input number into a channel register, an optional launch delay into a delay register, and a control word that carries the resolution, standby, the prescaler divisor and its enable, and a go bit. The block divides the bus clock into a converter clock-enable pulse train and waits the programmed number of those pulses. It then pulses a start line toward the converter with the channel held steady. When the converter reports done, the block latches the sample and raises a level interrupt.

The interrupt stays high until software writes a one into a dedicated clear register. Software reads the sample from a data register. In the reduced-resolution mode the two lowest sample bits are zeroed before latching, so software always sees a 12-bit field. The register bus is a single-cycle write strobe plus a combinational read port addressed by byte offset.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0x0000_0C40 (divisor 49 in bits 13:6, everything else zero); the delay (0x08), data (0x0C) and channel (0x1C) registers read zero and `irq` is low.
- R2: With control bit 14 set, `conv_clk_en` is high for one cycle out of every divisor+1 bus cycles; with bit 14 clear it stays low.
- R3: Writing control bit 0 as 1 while idle launches one conversion on the channel held in bits 2:0 of the channel register; `conv_chan` carries that channel during the `conv_start` pulse, and bit 0 always reads back as 0.
- R4: After a launch, `conv_start` pulses for one cycle, in the cycle right after the (D+1)-th `conv_clk_en` pulse, where D is the delay register value (bits 7:0).
- R5: While control bit 2 (standby) is set, `conv_standby` is high and a go write starts nothing.
- R6: A go write with bit 14 clear starts nothing.
- R7: Control bit 15 reads 1 from the launch until the done strobe and 0 otherwise; a go write while it is set causes no extra `conv_start`.
- R8: On `conv_done` during a conversion with bit 16 set (12-bit mode), the full 12-bit sample is latched into bits 11:0 of the data register; bits 31:12 read zero.
- R9: With bit 16 clear (10-bit mode), bits 1:0 of the latched sample are zero and bits 11:2 carry the converter's upper ten bits.
- R10: `irq` rises in the cycle after the done strobe and stays high until a write with bit 0 set to the clear register at 0x18; a write of 0 there leaves it high.
- R11: A `conv_done` pulse while no conversion is running changes neither the data register nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Conversion-complete interrupt, level |
| conv_chan | output | 3 | Channel presented to the converter |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_clk_en | output | 1 | Divided converter clock enable |
| conv_standby | output | 1 | Converter standby request |
| conv_result | input | 12 | Sample from the converter |
| conv_done | input | 1 | Converter completion strobe |

## Verification
The bench times the launch against the divided clock: a launch counted from the wrong pulse would show up as a tick count off by one against D+1. It repeats the go write while busy, where a sequencer that does not lock out would pulse the converter twice. It tries go writes with standby set and with the divider off; a design that lets either through would start the converter or raise `irq`. It also sends a stray done strobe while idle, which a design that latches without checking its state would let overwrite the data register and raise the interrupt.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    // Register byte offsets
    localparam logic [4:0] OFS_CTRL = 5'h00;
    localparam logic [4:0] OFS_DLY  = 5'h08;
    localparam logic [4:0] OFS_DATA = 5'h0C;
    localparam logic [4:0] OFS_ICLR = 5'h18;
    localparam logic [4:0] OFS_MUX  = 5'h1C;

    // Fixed control bit positions
    localparam int BIT_GO  = 0;
    localparam int BIT_SBY = 2;
    localparam int PSC_LSB = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CONV = 2'd2
    } seq_st_e;
endpackage

// File: rtl/adc_psc_div.sv
module adc_psc_div #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q >= div);
        cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
    parameter int RES_W  = 12,
    parameter int DROP_W = 2
) (
    input  logic [RES_W-1:0] raw,
    input  logic             hires,
    output logic [RES_W-1:0] fmt
);
    generate
        if (DROP_W == 0) begin : g_full
            assign fmt = raw;
        end else begin : g_drop
            assign fmt = hires ? raw : {raw[RES_W-1:DROP_W], {DROP_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W    = 3,
    parameter int DLY_W   = 8,
    parameter int PSC_W   = 8,
    parameter int RES_W   = 12,
    parameter int DROP_W  = 2,
    parameter int PSC_RST = 49
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [4:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq,
    output logic [CH_W-1:0]  conv_chan,
    output logic             conv_start,
    output logic             conv_clk_en,
    output logic             conv_standby,
    input  logic [RES_W-1:0] conv_result,
    input  logic             conv_done
);
    localparam int PEN_BIT   = PSC_LSB + PSC_W;
    localparam int BUSY_BIT  = PEN_BIT + 1;
    localparam int HIRES_BIT = BUSY_BIT + 1;

    typedef struct packed {
        seq_st_e          st;
        logic [DLY_W-1:0] wait_cnt;
        logic             go_pulse;
        logic             irq;
        logic [RES_W-1:0] data;
        logic             sby;
        logic             pen;
        logic [PSC_W-1:0] psc;
        logic             hires;
        logic [CH_W-1:0]  mux;
        logic [CH_W-1:0]  act_ch;
        logic [DLY_W-1:0] dly;
    } regs_t;

    regs_t            r_d, r_q;
    logic             tick;
    logic [RES_W-1:0] fmt_res;
    logic             busy_w, pen_w, hires_w;
    logic [RES_W-1:0] data_w;
    logic             wr_ctrl, go_ok;

    assign busy_w  = (r_q.st != ST_IDLE);
    assign pen_w   = r_q.pen;
    assign hires_w = r_q.hires;
    assign data_w  = r_q.data;

    adc_psc_div #(.PSC_W(PSC_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (pen_w),
        .div  (r_q.psc),
        .tick (tick)
    );

    adc_res_fmt #(.RES_W(RES_W), .DROP_W(DROP_W)) u_fmt (
        .raw  (conv_result),
        .hires(hires_w),
        .fmt  (fmt_res)
    );

    always_comb begin
        r_d          = r_q;
        r_d.go_pulse = 1'b0;
        wr_ctrl      = bus_wr && (bus_addr == OFS_CTRL);
        go_ok        = wr_ctrl && bus_wdata[BIT_GO] && bus_wdata[PEN_BIT]
                       && !bus_wdata[BIT_SBY];

        if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL: begin
                    r_d.sby   = bus_wdata[BIT_SBY];
                    r_d.pen   = bus_wdata[PEN_BIT];
                    r_d.psc   = bus_wdata[PSC_LSB +: PSC_W];
                    r_d.hires = bus_wdata[HIRES_BIT];
                end
                OFS_DLY:  r_d.dly = bus_wdata[DLY_W-1:0];
                OFS_MUX:  r_d.mux = bus_wdata[CH_W-1:0];
                OFS_ICLR: if (bus_wdata[0]) r_d.irq = 1'b0;
                default: ;
            endcase
        end

        case (r_q.st)
            ST_IDLE: begin
                if (go_ok) begin
                    r_d.st       = ST_WAIT;
                    r_d.wait_cnt = r_q.dly;
                    r_d.act_ch   = r_q.mux;
                end
            end
            ST_WAIT: begin
                if (tick) begin
                    if (r_q.wait_cnt == '0) begin
                        r_d.go_pulse = 1'b1;
                        r_d.st       = ST_CONV;
                    end else begin
                        r_d.wait_cnt = r_q.wait_cnt - 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    r_d.data = fmt_res;
                    r_d.irq  = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.psc <= PSC_W'(PSC_RST);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[BIT_SBY]             = r_q.sby;
                bus_rdata[PSC_LSB +: PSC_W]    = r_q.psc;
                bus_rdata[PEN_BIT]             = r_q.pen;
                bus_rdata[BUSY_BIT]            = busy_w;
                bus_rdata[HIRES_BIT]           = r_q.hires;
            end
            OFS_DLY:  bus_rdata[DLY_W-1:0] = r_q.dly;
            OFS_DATA: bus_rdata[RES_W-1:0] = data_w;
            OFS_MUX:  bus_rdata[CH_W-1:0]  = r_q.mux;
            default: ;
        endcase
    end

    assign irq          = r_q.irq;
    assign conv_chan    = r_q.act_ch;
    assign conv_start   = r_q.go_pulse;
    assign conv_clk_en  = tick;
    assign conv_standby = r_q.sby;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int RES_W   = 12,
    parameter int DROP_W  = 2,
    parameter int PEN_BIT = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [4:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             irq,
    input logic             conv_start,
    input logic             conv_clk_en,
    input logic             conv_done,
    input logic             busy_w,
    input logic             pen_w,
    input logic             hires_w,
    input logic [RES_W-1:0] data_w
);
    // R4
    start_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(conv_clk_en));

    // R10
    irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(conv_done));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && bus_addr == 5'h18 && bus_wdata[0])) |=> irq);

    // R5
    no_launch_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_w && bus_wr && bus_addr == 5'h00 && bus_wdata[0]
         && (bus_wdata[2] || !bus_wdata[PEN_BIT])) |=> !busy_w);

    // R2
    no_tick_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pen_w |-> !conv_clk_en);

    // R9
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && !$past(hires_w)) |-> (data_w[DROP_W-1:0] == '0));

    // R11
    idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_w && conv_done) |=> $stable(data_w));
endmodule

bind adc_seq_ctrl adc_seq_chk #(
    .RES_W  (RES_W),
    .DROP_W (DROP_W),
    .PEN_BIT(PEN_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq        (irq),
    .conv_start (conv_start),
    .conv_clk_en(conv_clk_en),
    .conv_done  (conv_done),
    .busy_w     (busy_w),
    .pen_w      (pen_w),
    .hires_w    (hires_w),
    .data_w     (data_w)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [2:0]  conv_chan;
    logic        conv_start, conv_clk_en, conv_standby;
    logic [11:0] conv_result = 12'h0;
    logic        conv_done = 1'b0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .conv_chan(conv_chan), .conv_start(conv_start), .conv_clk_en(conv_clk_en),
        .conv_standby(conv_standby), .conv_result(conv_result), .conv_done(conv_done)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // converter model
    logic [11:0] model_raw = 12'h0;
    bit  force_done = 0;
    bit  armed = 0, converting = 0;
    int  tick_seen = 0, got_ticks = 0, conv_left = 0, starts = 0;
    logic [2:0] got_ch = 3'h0;

    always @(negedge clk) begin
        conv_done = 1'b0;
        conv_result = model_raw;
        if (rst_n) begin
            if (bus_wr && bus_addr == 5'h00 && bus_wdata[0] && bus_wdata[14]
                && !bus_wdata[2] && !armed && !converting) begin
                armed = 1; tick_seen = 0;
            end else if (conv_start) begin
                starts++; got_ticks = tick_seen; got_ch = conv_chan;
                armed = 0; converting = 1; conv_left = 3;
            end else begin
                if (armed && conv_clk_en) tick_seen++;
                if (converting && conv_clk_en) begin
                    conv_left--;
                    if (conv_left == 0) begin conv_done = 1'b1; converting = 0; end
                end
            end
            if (force_done) begin conv_done = 1'b1; force_done = 0; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_irq(output bit seen);
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(posedge clk); #1;
            if (irq) seen = 1;
        end
    endtask

    typedef struct packed {
        logic [2:0]  ch;
        logic [7:0]  psc;
        logic [7:0]  dly;
        logic        hires;
        logic [11:0] raw;
        logic [11:0] exp;
    } vec_t;

    localparam vec_t TBL [5] = '{
        '{3'd5, 8'd0, 8'd0, 1'b1, 12'hFFF, 12'hFFF},
        '{3'd2, 8'd3, 8'd2, 1'b0, 12'hA5B, 12'hA58},
        '{3'd7, 8'd1, 8'd5, 1'b1, 12'h123, 12'h123},
        '{3'd0, 8'd4, 8'd1, 1'b0, 12'h003, 12'h000},
        '{3'd3, 8'd2, 8'd3, 1'b1, 12'h801, 12'h801}
    };

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cw;
        bit seen;
        int base, gap;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(5'h00, v); chk("R1 ctrl", v, 32'h0000_0C40);
        rd(5'h08, v); chk("R1 dly", v, 32'h0);
        rd(5'h0C, v); chk("R1 data", v, 32'h0);
        rd(5'h1C, v); chk("R1 mux", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // vector walk
        foreach (TBL[k]) begin
            model_raw = TBL[k].raw;
            wr(5'h1C, {29'h0, TBL[k].ch});
            wr(5'h08, {24'h0, TBL[k].dly});
            base = starts;
            cw = ({31'h0, TBL[k].hires} << 16) | (32'h1 << 14)
                 | ({24'h0, TBL[k].psc} << 6) | 32'h1;
            wr(5'h00, cw);
            rd(5'h00, v);
            chk("R7 busy set", {31'h0, v[15]}, 32'h1);
            chk("R3 go reads 0", {31'h0, v[0]}, 32'h0);
            wr(5'h00, cw);  // second go while busy
            wait_irq(seen);
            chk("R10 irq raised", {31'h0, seen}, 32'h1);
            chk("R7 single start", starts, base + 1);
            chk("R3 channel", {29'h0, got_ch}, {29'h0, TBL[k].ch});
            chk("R4 launch ticks", got_ticks, {24'h0, TBL[k].dly} + 1);
            rd(5'h0C, v);
            if (TBL[k].hires) chk("R8 data 12b", v, {20'h0, TBL[k].exp});
            else              chk("R9 data 10b", v, {20'h0, TBL[k].exp});
            rd(5'h00, v);
            chk("R7 busy clear", {31'h0, v[15]}, 32'h0);
            idle(5);
            wr(5'h18, 32'h0);
            chk("R10 hold after write 0", {31'h0, irq}, 32'h1);
            wr(5'h18, 32'h1);
            chk("R10 cleared", {31'h0, irq}, 32'h0);
        end

        // R11 stray done while idle
        model_raw = 12'h555;
        @(posedge clk); #1; force_done = 1;
        idle(4);
        rd(5'h0C, v); chk("R11 data kept", v, 32'h801);
        chk("R11 irq low", {31'h0, irq}, 32'h0);

        // R2 tick period with divisor 3
        wr(5'h00, (32'h1 << 14) | (32'd3 << 6));
        gap = 0;
        for (int i = 0; i < 20 && !conv_clk_en; i++) begin @(posedge clk); #1; end
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1; gap++;
            if (conv_clk_en) break;
        end
        chk("R2 tick period", gap, 4);
        wr(5'h00, (32'd3 << 6));
        gap = 0;
        for (int i = 0; i < 20; i++) begin @(posedge clk); #1; if (conv_clk_en) gap++; end
        chk("R2 no tick when off", gap, 0);

        // R6 go with divider off
        base = starts;
        wr(5'h00, (32'd3 << 6) | 32'h1);
        rd(5'h00, v); chk("R6 not busy", {31'h0, v[15]}, 32'h0);
        idle(50);
        chk("R6 no start", starts, base);
        chk("R6 no irq", {31'h0, irq}, 32'h0);

        // R5 go with standby
        wr(5'h00, (32'h1 << 14) | (32'd1 << 6) | 32'h4 | 32'h1);
        chk("R5 standby out", {31'h0, conv_standby}, 32'h1);
        rd(5'h00, v); chk("R5 not busy", {31'h0, v[15]}, 32'h0);
        idle(50);
        chk("R5 no start", starts, base);
        chk("R5 no irq", {31'h0, irq}, 32'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule